// File: doc/BRIEF.md
# Dual Threshold Trigger for Multi-Sample Channels

This block watches one digitized channel that presents a group of signed samples on every clock. Lane 0 holds the earliest sample of the group and the last lane holds the newest. Each of two independent trigger units compares every lane of the group against its own signed threshold during the same clock. A unit is either a level detector or an edge detector, and it works in either the rising or the falling direction.

For each clock, each unit reports a registered flag and the lowest lane that met its condition. In edge mode a crossing can fall between the newest lane of one group and lane 0 of the next group, so the unit keeps the newest sample of the last valid group. The two units can also act as a window pair. One unit is set to falling level on an upper bound and the other to rising level on a lower bound. The window flag is raised when a single lane satisfies both units.

Top module: `dual_thresh_trigger`

## Requirements
- R1: While `rst_n` is low, all outputs are 0. This includes the cycle in which reset is asserted, because the reset clears the outputs asynchronously.
- R2: Rising level mode (`edge_x`=0, `fall_x`=0). A unit fires when any lane is strictly greater than its threshold.
- R3: Falling level mode (`edge_x`=0, `fall_x`=1). A unit fires when any lane is strictly less than its threshold.
- R4: Rising edge mode (`edge_x`=1, `fall_x`=0). Lane i fires when the preceding sample is at or below the threshold and lane i is strictly above it. A sample equal to the threshold followed by the same value does not fire.
- R5: Falling edge mode (`edge_x`=1, `fall_x`=1). Lane i fires when the preceding sample is at or above the threshold and lane i is strictly below it.
- R6: For lane 0, the preceding sample is the newest lane of the last group accepted with `en` and `valid` both high.
- R7: Lane 0 cannot produce an edge on the first accepted group after reset. The same holds for the first accepted group after `en` returns high.
- R8: A cycle with `en` or `valid` low produces no trigger. A cycle with `valid` low leaves the stored previous sample unchanged.
- R9: Flags and indices appear one clock after the samples are presented. The index is the lowest firing lane, and it is 0 when the flag is low.
- R10: Unit A and unit B are evaluated independently. `win_trig` is high when at least one lane fired in both units. `win_idx` is the lowest such lane.
- R11: Samples and thresholds are compared as two's-complement signed numbers. Negative thresholds and the extreme values work correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables detection; while low, the previous-sample history is forgotten |
| valid | input | 1 | Marks the current sample group as real data |
| samples | input | LANES*SW | Sample group; lane i occupies bits [i*SW +: SW] |
| thr_a | input | SW | Signed threshold, unit A |
| edge_a | input | 1 | Unit A: 1 = edge, 0 = level |
| fall_a | input | 1 | Unit A: 1 = falling, 0 = rising |
| thr_b | input | SW | Signed threshold, unit B |
| edge_b | input | 1 | Unit B: 1 = edge, 0 = level |
| fall_b | input | 1 | Unit B: 1 = falling, 0 = rising |
| trig_a | output | 1 | Unit A fired |
| idx_a | output | IW | Lowest firing lane, unit A |
| trig_b | output | 1 | Unit B fired |
| idx_b | output | IW | Lowest firing lane, unit B |
| win_trig | output | 1 | Some lane fired in both units |
| win_idx | output | IW | Lowest lane that fired in both units |

## Verification
The bench runs through the following corner cases:

- **Threshold equality.** A sample equal to the threshold must not count as beyond it. A design that used non-strict compares would fire on the equal lane or report a lower index.
- **Crossing between groups.** The newest lane of one group and lane 0 of the next group form a crossing. A design that ignored the held sample would miss it.
- **Held sample across invalid cycles.** If the held sample were overwritten during a cycle with `valid` low, the bench would see a missed or a spurious crossing.
- **First group after reset or re-enable.** A design that trusted the reset value of the held sample would report a false lane-0 edge on that group.
- **Signed compares and window coincidence.** Negative and extreme thresholds expose unsigned compares. Lanes that satisfy each bound separately, but never on the same lane, expose a window built from the two unit flags instead of per-lane coincidence.

// File: rtl/dual_thresh_trigger.sv
module dual_thresh_trigger #(
  parameter int LANES = 4,
  parameter int SW = 16,
  localparam int IW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              valid,
  input  logic [LANES*SW-1:0] samples,
  input  logic [SW-1:0]     thr_a,
  input  logic              edge_a,
  input  logic              fall_a,
  input  logic [SW-1:0]     thr_b,
  input  logic              edge_b,
  input  logic              fall_b,
  output logic              trig_a,
  output logic [IW-1:0]     idx_a,
  output logic              trig_b,
  output logic [IW-1:0]     idx_b,
  output logic              win_trig,
  output logic [IW-1:0]     win_idx
);

  logic signed [SW-1:0] lane [LANES];
  logic signed [SW-1:0] thr [2];
  logic                 edm [2];
  logic                 flm [2];
  logic [LANES-1:0]     hv [2];
  logic signed [SW-1:0] last_q;
  logic                 have_prev_q;
  logic                 go;

  assign thr[0] = thr_a;
  assign thr[1] = thr_b;
  assign edm[0] = edge_a;
  assign edm[1] = edge_b;
  assign flm[0] = fall_a;
  assign flm[1] = fall_b;
  assign go = en & valid;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane[i] = samples[i*SW +: SW];
  end

  for (genvar u = 0; u < 2; u++) begin : g_unit
    for (genvar i = 0; i < LANES; i++) begin : g_cmp
      logic signed [SW-1:0] prev;
      logic                 p_ok;
      logic                 above, below, p_up, p_dn;
      if (i == 0) begin : g_first
        assign prev = last_q;
        assign p_ok = have_prev_q;
      end else begin : g_inner
        assign prev = lane[i-1];
        assign p_ok = 1'b1;
      end
      assign above = lane[i] > thr[u];
      assign below = lane[i] < thr[u];
      assign p_up  = prev <= thr[u];
      assign p_dn  = prev >= thr[u];
      assign hv[u][i] = edm[u] ? (p_ok & (flm[u] ? (p_dn & below) : (p_up & above)))
                               : (flm[u] ? below : above);
    end
  end

  function automatic logic [IW-1:0] first_idx(input logic [LANES-1:0] v);
    first_idx = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (v[i]) first_idx = i[IW-1:0];
  endfunction

  logic [LANES-1:0] wv;
  assign wv = hv[0] & hv[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_a      <= 1'b0;
      idx_a       <= '0;
      trig_b      <= 1'b0;
      idx_b       <= '0;
      win_trig    <= 1'b0;
      win_idx     <= '0;
      last_q      <= '0;
      have_prev_q <= 1'b0;
    end else begin
      trig_a   <= go & (|hv[0]);
      idx_a    <= go ? first_idx(hv[0]) : '0;
      trig_b   <= go & (|hv[1]);
      idx_b    <= go ? first_idx(hv[1]) : '0;
      win_trig <= go & (|wv);
      win_idx  <= go ? first_idx(wv) : '0;
      if (go) last_q <= lane[LANES-1];
      if (!en) have_prev_q <= 1'b0;
      else if (valid) have_prev_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dual_thresh_trigger_chk.sv
module dual_thresh_trigger_chk #(
  parameter int IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          valid,
  input logic          trig_a,
  input logic [IW-1:0] idx_a,
  input logic          trig_b,
  input logic [IW-1:0] idx_b,
  input logic          win_trig,
  input logic [IW-1:0] win_idx
);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || !valid) |=> (!trig_a && !trig_b && !win_trig));

  // R9
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_a |-> idx_a == '0) and (!trig_b |-> idx_b == '0));

  // R9
  win_idx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_trig |-> win_idx == '0);

  // R10
  win_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_trig |-> (trig_a && trig_b));

  // R10
  win_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_trig |-> (win_idx >= idx_a && win_idx >= idx_b));

endmodule

bind dual_thresh_trigger dual_thresh_trigger_chk #(.IW(IW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(en), .valid(valid),
  .trig_a(trig_a), .idx_a(idx_a), .trig_b(trig_b), .idx_b(idx_b),
  .win_trig(win_trig), .win_idx(win_idx)
);

// File: tb/dual_thresh_trigger_tb_top.sv
module dual_thresh_trigger_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, valid = 1'b0;
  logic [63:0] samples = '0;
  logic [15:0] thr_a = '0, thr_b = '0;
  logic edge_a = 1'b0, fall_a = 1'b0, edge_b = 1'b0, fall_b = 1'b0;
  logic trig_a, trig_b, win_trig;
  logic [1:0] idx_a, idx_b, win_idx;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dual_thresh_trigger dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .valid(valid), .samples(samples),
    .thr_a(thr_a), .edge_a(edge_a), .fall_a(fall_a),
    .thr_b(thr_b), .edge_b(edge_b), .fall_b(fall_b),
    .trig_a(trig_a), .idx_a(idx_a), .trig_b(trig_b), .idx_b(idx_b),
    .win_trig(win_trig), .win_idx(win_idx)
  );

  typedef struct packed {
    logic signed [15:0] s0, s1, s2, s3;
    logic signed [15:0] ta; logic ea, fa;
    logic signed [15:0] tb; logic eb, fb;
    logic xa; logic [1:0] ia;
    logic xb; logic [1:0] ib;
    logic xw; logic [1:0] iw;
  } vec_t;

  localparam vec_t TBL [8] = '{
    // R2 R3: level rising A, level falling B
    '{16'sd100, 16'sd200, 16'sd300, 16'sd400, 16'sd250, 1'b0, 1'b0, 16'sd150, 1'b0, 1'b1,
      1'b1, 2'd2, 1'b1, 2'd0, 1'b0, 2'd0},
    // R4 R5 R6: edges, lane0 falling crossing from previous group
    '{-16'sd5, 16'sd0, 16'sd7, -16'sd3, 16'sd0, 1'b1, 1'b0, 16'sd0, 1'b1, 1'b1,
      1'b1, 2'd2, 1'b1, 2'd0, 1'b0, 2'd0},
    // R6: lane0 rising crossing from previous group
    '{16'sd10, 16'sd20, 16'sd30, 16'sd40, 16'sd0, 1'b1, 1'b0, 16'sd0, 1'b1, 1'b1,
      1'b1, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0},
    // R4 R5: samples equal to threshold
    '{16'sd40, 16'sd40, 16'sd41, 16'sd0, 16'sd40, 1'b1, 1'b0, 16'sd40, 1'b1, 1'b1,
      1'b1, 2'd2, 1'b1, 2'd3, 1'b0, 2'd0},
    // R11: negative thresholds
    '{-16'sd20000, -16'sd5000, -16'sd10000, -16'sd10001, -16'sd10000, 1'b0, 1'b1, -16'sd10000, 1'b0, 1'b0,
      1'b1, 2'd0, 1'b1, 2'd1, 1'b0, 2'd0},
    // R10: window hit on lanes 2 and 3
    '{16'sd5000, 16'sd2000, 16'sd500, -16'sd300, 16'sd1000, 1'b0, 1'b1, -16'sd1000, 1'b0, 1'b0,
      1'b1, 2'd2, 1'b1, 2'd0, 1'b1, 2'd2},
    // R10: both units fire, never on the same lane
    '{-16'sd2000, 16'sd3000, -16'sd1500, 16'sd1000, 16'sd1000, 1'b0, 1'b1, -16'sd1000, 1'b0, 1'b0,
      1'b1, 2'd0, 1'b1, 2'd1, 1'b0, 2'd0},
    // R9 R11: extreme thresholds, no trigger
    '{16'sd1, 16'sd2, 16'sd3, 16'sd4, 16'sd32767, 1'b0, 1'b0, 16'sh8000, 1'b0, 1'b1,
      1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 2'd0}
  };

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic all4(logic signed [15:0] v);
    samples = {v, v, v, v};
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 trig_a in reset", trig_a, 0);
    check("R1 trig_b in reset", trig_b, 0);
    check("R1 win in reset", win_trig, 0);
    rst_n = 1'b1;
    en = 1'b1;
    valid = 1'b1;
    for (int k = 0; k < 8; k++) begin
      samples = {TBL[k].s3, TBL[k].s2, TBL[k].s1, TBL[k].s0};
      thr_a = TBL[k].ta; edge_a = TBL[k].ea; fall_a = TBL[k].fa;
      thr_b = TBL[k].tb; edge_b = TBL[k].eb; fall_b = TBL[k].fb;
      cyc();
      check($sformatf("R2-table row%0d trig_a", k), trig_a, TBL[k].xa);
      check($sformatf("R9 row%0d idx_a", k), idx_a, TBL[k].ia);
      check($sformatf("R3-table row%0d trig_b", k), trig_b, TBL[k].xb);
      check($sformatf("R9 row%0d idx_b", k), idx_b, TBL[k].ib);
      check($sformatf("R10 row%0d win", k), win_trig, TBL[k].xw);
      check($sformatf("R10 row%0d win_idx", k), win_idx, TBL[k].iw);
    end

    rst_n = 1'b0;
    cyc();
    rst_n = 1'b1;
    thr_a = 16'sd0; edge_a = 1'b1; fall_a = 1'b0;
    thr_b = 16'sd0; edge_b = 1'b1; fall_b = 1'b1;
    all4(16'sd5);
    cyc();
    check("R7 no lane0 edge after reset", trig_a, 0);
    all4(-16'sd5);
    cyc();
    check("R6 falling across groups", trig_b, 1);
    check("R6 falling idx", idx_b, 0);
    en = 1'b0;
    all4(16'sd5);
    cyc();
    check("R8 en low trig_a", trig_a, 0);
    check("R8 en low trig_b", trig_b, 0);
    en = 1'b1;
    cyc();
    check("R7 no lane0 edge after re-enable", trig_a, 0);
    all4(-16'sd5);
    cyc();
    check("R5 falling after re-enable", trig_b, 1);
    valid = 1'b0;
    all4(16'sd100);
    cyc();
    check("R8 valid low trig_a", trig_a, 0);
    check("R8 valid low trig_b", trig_b, 0);
    valid = 1'b1;
    all4(16'sd5);
    #1;
    check("R9 no output before edge", trig_a, 0);
    @(negedge clk);
    check("R8 prev held over invalid cycle", trig_a, 1);
    check("R8 prev held idx", idx_a, 0);
    rst_n = 1'b0;
    #1;
    check("R1 async clear trig_a", trig_a, 0);
    check("R1 async clear idx_a", idx_a, 0);
    finish_run();
  end

endmodule